// File: doc/BRIEF.md
# Block Lookahead Binary Adder

This block adds two unsigned operands and an incoming carry in a single combinational step. It returns the sum and the carry leaving the top bit. Each bit column forms a generate term and a propagate term. Propagate is taken as the OR of the two operand bits. Fixed-size groups of columns fold these terms into one group generate bit and one group propagate bit. The carry entering each group is then produced from the carry entering the group before it, so a carry does not have to step through every bit on its way up.

Inside a group, the carry into each column is rebuilt from that group's carry-in and its column terms. Each sum bit is the XOR of the two operand bits and the carry entering that column. The operand width and the group size are parameters. The default is 32 bits in eight groups of four, with group boundaries after bits 3, 7, 11, 15, 19, 23 and 27, and the final carry taken out of bit 31. The block has no registers, so its outputs follow its inputs within the same cycle.

Top module: `cla_adder`

## Requirements
- R1: {carry_o, sum_o} equals a_i + b_i + carry_i, evaluated at WIDTH+1 bits, for every input combination.
- R2: A column whose two operand bits are both 1 both generates and propagates. With every bit of both operands set and carry_i = 1, sum_o is all ones and carry_o = 1.
- R3: The carry leaving a group equals that group's generate OR (its propagate AND its carry-in). For example, 0x0000000F + 0x00000001 gives 0x00000010 with no carry out.
- R4: When every column propagates, a carry entering at bit 0 reaches carry_o. All ones + 0 + carry_i=1 gives sum_o = 0 and carry_o = 1.
- R5: All ones + 1 with carry_i = 0 gives sum_o = 0 and carry_o = 1.
- R6: With both operands zero, the result is sum_o = carry_i and carry_o = 0.
- R7: WIDTH must be a whole multiple of BLOCK_BITS, and elaboration stops otherwise. Any such width works, for example WIDTH = 12.
- R8: Each sum bit is operand bit A XOR operand bit B XOR the carry into that column. Operands with no overlapping 1 bits and carry_i = 0 give their bitwise OR.
- R9: The carry entering an upper group is formed from the lower groups alone. 0x0FFFFFFF + 0 + 1 gives 0x10000000 with no carry out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum, modulo 2^WIDTH |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
The bench aims at carries that have to cross group boundaries. A single carry must travel from bit 0 through every group. A carry must stop exactly at a group edge. Both operands may be all ones, so generate and propagate are true together. A design that wired the wrong group term into the chain would lose the carry at some boundary, giving 0xFFFFFFF0-style leftovers or a missing 0x10000000. A design that used the propagate term in place of the XOR when forming the sum would go wrong whenever both operand bits are 1, for example all ones plus all ones. A second, narrower instance shows that the group count follows the width parameter, and a mistake in deriving that count would leave the upper bits wrong.

// File: rtl/cla_pkg.sv
package cla_pkg;
   // generate / propagate pair for a column or a group
   typedef struct packed {
      logic gen;
      logic prop;
   } gp_t;

   function automatic int unsigned group_count(input int unsigned width, input int unsigned grp);
      return width / grp;
   endfunction
endpackage

// File: rtl/cla_column_pg.sv
module cla_column_pg #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] gen_o,
   output logic [WIDTH-1:0] prop_o
);
   for (genvar col = 0; col < WIDTH; col++) begin : g_col
      assign gen_o[col]  = a_i[col] & b_i[col];
      assign prop_o[col] = a_i[col] | b_i[col];
   end

   // R2: a generating column must also propagate
   always_comb begin
      if (!$isunknown({gen_o, prop_o}))
         assert_gen_implies_prop_R2: assert ((gen_o & ~prop_o) == '0)
            else $error("column generates without propagating");
   end
endmodule

// File: rtl/cla_group_pg.sv
module cla_group_pg #(
   parameter int unsigned BLOCK_BITS = 4
) (
   input  logic [BLOCK_BITS-1:0] gen_i,
   input  logic [BLOCK_BITS-1:0] prop_i,
   output cla_pkg::gp_t          grp_o
);
   if (BLOCK_BITS == 4) begin : g_four
      // nested form for the default group size
      assign grp_o.gen  = gen_i[3] | (prop_i[3] & (gen_i[2] | (prop_i[2] &
                          (gen_i[1] | (prop_i[1] & gen_i[0])))));
      assign grp_o.prop = prop_i[3] & prop_i[2] & prop_i[1] & prop_i[0];
   end else begin : g_any
      always_comb begin
         logic g_acc;
         logic p_acc;
         g_acc = gen_i[0];
         p_acc = prop_i[0];
         for (int k = 1; k < BLOCK_BITS; k++) begin
            g_acc = gen_i[k] | (prop_i[k] & g_acc);
            p_acc = p_acc & prop_i[k];
         end
         grp_o.gen  = g_acc;
         grp_o.prop = p_acc;
      end
   end
endmodule

// File: rtl/cla_carry_chain.sv
module cla_carry_chain #(
   parameter int unsigned NUM_GROUPS = 8
) (
   input  logic                          carry_i,
   input  cla_pkg::gp_t [NUM_GROUPS-1:0] grp_i,
   output logic [NUM_GROUPS-1:0]         grp_cin_o,
   output logic                          carry_o
);
   logic [NUM_GROUPS:0] chain;

   assign chain[0] = carry_i;
   for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_link
      assign chain[k+1]   = grp_i[k].gen | (grp_i[k].prop & chain[k]);
      assign grp_cin_o[k] = chain[k];
   end
   assign carry_o = chain[NUM_GROUPS];

   // R4: if every group propagates, the final carry is the incoming one
   always_comb begin
      logic all_prop;
      logic any_gen;
      all_prop = 1'b1;
      any_gen  = 1'b0;
      for (int k = 0; k < NUM_GROUPS; k++) begin
         all_prop = all_prop & grp_i[k].prop;
         any_gen  = any_gen | grp_i[k].gen;
      end
      if (!$isunknown({carry_i, grp_i}) && all_prop && !any_gen)
         assert_full_prop_R4: assert (carry_o == carry_i)
            else $error("carry lost across a fully propagating chain");
   end
endmodule

// File: rtl/cla_group_sum.sv
module cla_group_sum #(
   parameter int unsigned BLOCK_BITS = 4
) (
   input  logic [BLOCK_BITS-1:0] a_i,
   input  logic [BLOCK_BITS-1:0] b_i,
   input  logic [BLOCK_BITS-1:0] gen_i,
   input  logic [BLOCK_BITS-1:0] prop_i,
   input  cla_pkg::gp_t          grp_i,
   input  logic                  cin_i,
   output logic [BLOCK_BITS-1:0] sum_o
);
   logic [BLOCK_BITS:0] col_c;

   assign col_c[0] = cin_i;
   for (genvar j = 0; j < BLOCK_BITS; j++) begin : g_bit
      assign col_c[j+1] = gen_i[j] | (prop_i[j] & col_c[j]);
      assign sum_o[j]   = a_i[j] ^ b_i[j] ^ col_c[j];
   end

   always_comb begin
      logic [BLOCK_BITS:0] wide;
      if (!$isunknown({a_i, b_i, cin_i, grp_i})) begin
         // R3: group-level carry agrees with the column-by-column carry
         assert_grp_carry_R3: assert ((grp_i.gen | (grp_i.prop & cin_i)) == col_c[BLOCK_BITS])
            else $error("group carry mismatch");
         // R8: the group's sum bits are the arithmetic sum of its slice
         wide = {1'b0, a_i} + {1'b0, b_i} + {{BLOCK_BITS{1'b0}}, cin_i};
         assert_grp_sum_R8: assert (sum_o == wide[BLOCK_BITS-1:0])
            else $error("group sum mismatch");
      end
   end
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
   parameter int unsigned WIDTH      = 32,
   parameter int unsigned BLOCK_BITS = 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             carry_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             carry_o
);
   localparam int unsigned NUM_GROUPS = cla_pkg::group_count(WIDTH, BLOCK_BITS);

   // R7: width must split evenly into groups
   if (BLOCK_BITS == 0 || WIDTH == 0 || (WIDTH % BLOCK_BITS) != 0) begin : g_bad_cfg
      $error("cla_adder: WIDTH must be a nonzero multiple of BLOCK_BITS");
   end

   logic [WIDTH-1:0]                col_g;
   logic [WIDTH-1:0]                col_p;
   cla_pkg::gp_t [NUM_GROUPS-1:0]   grp;
   logic [NUM_GROUPS-1:0]           grp_cin;

   cla_column_pg #(.WIDTH(WIDTH)) u_cols (
      .a_i    (a_i),
      .b_i    (b_i),
      .gen_o  (col_g),
      .prop_o (col_p)
   );

   for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
      localparam int unsigned LO = k * BLOCK_BITS;

      cla_group_pg #(.BLOCK_BITS(BLOCK_BITS)) u_pg (
         .gen_i  (col_g[LO +: BLOCK_BITS]),
         .prop_i (col_p[LO +: BLOCK_BITS]),
         .grp_o  (grp[k])
      );

      cla_group_sum #(.BLOCK_BITS(BLOCK_BITS)) u_sum (
         .a_i    (a_i[LO +: BLOCK_BITS]),
         .b_i    (b_i[LO +: BLOCK_BITS]),
         .gen_i  (col_g[LO +: BLOCK_BITS]),
         .prop_i (col_p[LO +: BLOCK_BITS]),
         .grp_i  (grp[k]),
         .cin_i  (grp_cin[k]),
         .sum_o  (sum_o[LO +: BLOCK_BITS])
      );
   end

   cla_carry_chain #(.NUM_GROUPS(NUM_GROUPS)) u_chain (
      .carry_i   (carry_i),
      .grp_i     (grp),
      .grp_cin_o (grp_cin),
      .carry_o   (carry_o)
   );

   // R1: full-width result equals the arithmetic sum
   always_comb begin
      logic [WIDTH:0] ref_sum;
      if (!$isunknown({a_i, b_i, carry_i})) begin
         ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};
         assert_total_R1: assert ({carry_o, sum_o} == ref_sum)
            else $error("adder result mismatch");
      end
   end
endmodule

// File: tb/cla_adder_tb_top.sv
module cla_adder_tb_top;
   localparam int unsigned W  = 32;
   localparam int unsigned WN = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;  // 250 MHz

   logic [W-1:0]  a, b, s;
   logic          ci, co;
   logic [WN-1:0] an, bn, sn;
   logic          cin_n, con;

   int checks = 0;
   int bad    = 0;
   int cycles = 0;
   bit done   = 1'b0;

   cla_adder #(.WIDTH(W), .BLOCK_BITS(4)) dut_i (
      .a_i(a), .b_i(b), .carry_i(ci), .sum_o(s), .carry_o(co));

   cla_adder #(.WIDTH(WN), .BLOCK_BITS(4)) dut_n (
      .a_i(an), .b_i(bn), .carry_i(cin_n), .sum_o(sn), .carry_o(con));

   function automatic logic [W:0] expect_w(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
      return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
   endfunction

   function automatic logic [WN:0] expect_n(input logic [WN-1:0] x, input logic [WN-1:0] y, input logic c);
      return {1'b0, x} + {1'b0, y} + {{WN{1'b0}}, c};
   endfunction

   task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input string req);
      logic [W:0] exp_v;
      @(posedge clk);
      a = x; b = y; ci = c;
      @(negedge clk);
      exp_v = expect_w(x, y, c);
      checks++;
      if ({co, s} !== exp_v) begin
         bad++;
         $display("FAIL %s: a=%h b=%h cin=%0d got carry=%0d sum=%h expected carry=%0d sum=%h",
                  req, x, y, c, co, s, exp_v[W], exp_v[W-1:0]);
      end
   endtask

   task automatic apply_n(input logic [WN-1:0] x, input logic [WN-1:0] y, input logic c);
      logic [WN:0] exp_v;
      @(posedge clk);
      an = x; bn = y; cin_n = c;
      @(negedge clk);
      exp_v = expect_n(x, y, c);
      checks++;
      if ({con, sn} !== exp_v) begin
         bad++;
         $display("FAIL R7: a=%h b=%h cin=%0d got %h expected %h", x, y, c, {con, sn}, exp_v);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         checks++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed;
      seed = 32'd20231;
      void'($urandom(seed));
      a = '0; b = '0; ci = 1'b0;
      an = '0; bn = '0; cin_n = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      apply('0, '0, 1'b0, "R6 zero");
      apply('0, '0, 1'b1, "R6 cin only");
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R2 both all ones");
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R2 both all ones no cin");
      apply(32'h0000_000F, 32'h0000_0001, 1'b0, "R3 group edge");
      apply(32'h0000_00F0, 32'h0000_0010, 1'b0, "R3 second group edge");
      apply(32'hFFFF_FFFF, 32'h0, 1'b1, "R4 full propagate");
      apply(32'hFFFF_FFFF, 32'h1, 1'b0, "R5 all ones plus one");
      apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b0, "R8 disjoint bits");
      apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R8 disjoint bits with cin");
      apply(32'h0FFF_FFFF, 32'h0, 1'b1, "R9 carry into top group");
      apply(32'h00FF_0000, 32'h0001_0000, 1'b0, "R9 mid group carry");
      apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R1 top bit carry");

      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] x, y;
         x = $urandom();
         y = $urandom();
         // bias some vectors toward long propagate runs
         if (i % 4 == 1) y = ~x;
         if (i % 4 == 2) y = ~x ^ (32'h1 << ($urandom() % 32));
         apply(x, y, 1'($urandom()), "R1 random");
      end

      apply_n(12'hFFF, 12'h001, 1'b0);
      apply_n(12'hFFF, 12'h000, 1'b1);
      apply_n(12'h0FF, 12'h001, 1'b0);
      for (int i = 0; i < 100; i++)
         apply_n(12'($urandom()), 12'($urandom()), 1'($urandom()));

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule